// File: doc/BRIEF.md
# Flash Buffered-Program Sequencer

This block performs one buffered program on a parallel NOR-style flash. It takes a request (a start word address and a word count from 1 to 32), then a stream of 16-bit data words. It turns these into the flash command sequence. The flash side is modelled as synchronous strobes: a write strobe with an address and a 16-bit data word, and a read strobe. The read strobe returns the status byte on `fl_rdata` in the next cycle.

The sequence runs as follows:
- **Setup and availability poll.** The sequencer writes the setup command to the start address and reads status there. It repeats this pair until status bit 7 reports a free write buffer. The number of attempts is bounded by a retry limit.
- **Load.** It writes the encoded word count, then one data word per write at consecutive addresses.
- **Confirm and completion poll.** It writes the confirm command to the start address. It then polls status until the internal state machine is ready.
- **Return to read mode.** Whether the run ended normally or was abandoned, the last bus operation is the read-array command.

A single-cycle `done` pulse ends every accepted request. It is shown together with `aborted` and the last status byte read.

Top module: `flash_bufprog_seq`

## Requirements
- R1: A request whose count is 0 or greater than 32 is refused. `req_err` is high for exactly the one cycle after acceptance, no flash read or write follows, and `req_ready` stays high.
- R2: A request whose start offset within its 32-word buffer (address bits 4:0) plus its count exceeds 32 is refused in the same way as R1. A request that ends exactly on the boundary (for example offset 31, count 1) is accepted.
- R3: The first bus operation of an accepted request is a write of 0x00E8 to the start address. It is followed in the next cycle by a status read at the same address.
- R4: If status bit 7 reads 0 after setup, the setup write and status read are repeated. After MAX_POLLS (default 8) consecutive replies with bit 7 at 0, the run is abandoned. No count, data or confirm write is made, and `aborted` is high during the `done` pulse. If bit 7 reads 1 on the last permitted attempt, the run continues normally.
- R5: Once the buffer is available, the count is written to the start address with bits 7:0 equal to count minus one and bits 15:8 equal to zero.
- R6: Data words are taken through `wr_valid`/`wr_ready`. Word i is written to start address plus i, in arrival order. Gaps in `wr_valid` produce no bus write.
- R7: After the last data word, 0x00D0 is written to the start address.
- R8: After the confirm write, status is read at the start address repeatedly until bit 7 reads 1.
- R9: The last bus write of every accepted request is 0x00FF to the start address. It is followed by a one-cycle `done` pulse. During that pulse, `status` shows the last status byte read and `aborted` is low on a completed program.
- R10: `req_ready` is low from acceptance until the `done` pulse has passed. A write strobe and a read strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken on valid |
| req_addr | input | ADDR_W (23) | Start word address |
| req_len | input | LEN_W (6) | Word count, 1 to 32 legal |
| wr_valid | input | 1 | Data word offered |
| wr_ready | output | 1 | Sequencer accepting data |
| wr_data | input | 16 | Data word |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash status read strobe |
| fl_addr | output | ADDR_W (23) | Flash word address |
| fl_wdata | output | 16 | Flash write data |
| fl_rdata | input | 16 | Flash read data, valid the cycle after `fl_re` |
| done | output | 1 | One-cycle end-of-run pulse |
| aborted | output | 1 | With `done`: buffer never became available |
| status | output | 8 | Last status byte read |
| req_err | output | 1 | One-cycle pulse for a refused request |

## Verification
Two events can meet in the same cycle: the retry limit expiring, and the flash finally reporting a free buffer on that same attempt. The bench's flash model is told to answer busy exactly MAX_POLLS−1 times and then ready. The bench then expects the count write to follow and `aborted` to stay low. A second run with MAX_POLLS busy replies must instead go straight from the last setup to the read-array write and flag an abort. Both outcomes are judged from the logged bus writes, the read count and the `done`-cycle outputs, all computed in the bench.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    localparam logic [7:0] CMD_BUF_SETUP  = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam int         STAT_READY_BIT = 7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_AV_RD,
        S_AV_CHK,
        S_COUNT,
        S_DATA,
        S_CONF,
        S_DN_RD,
        S_DN_CHK,
        S_RDARR,
        S_FIN
    } fbp_state_e;

    typedef struct packed {
        logic        we;
        logic        re;
        logic [15:0] data;
    } fbp_bus_t;

    function automatic logic [15:0] cmd_word(input logic [7:0] c);
        return {8'h00, c};
    endfunction

endpackage

// File: rtl/fbp_req_check.sv
module fbp_req_check #(
    parameter int BUF_WORDS = 32,
    localparam int OFF_W = $clog2(BUF_WORDS),
    localparam int LEN_W = OFF_W + 1
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [LEN_W-1:0] len,
    output logic             ok
);
    logic [LEN_W:0] span;

    always_comb begin
        span = (LEN_W + 1)'(offset) + (LEN_W + 1)'(len);
        ok   = (len != '0) && (len <= LEN_W'(BUF_WORDS)) && (span <= (LEN_W + 1)'(BUF_WORDS));
    end
endmodule

// File: rtl/fbp_poll_timer.sv
module fbp_poll_timer #(
    parameter int MAX_POLLS = 8,
    localparam int CW = $clog2(MAX_POLLS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (step && !last) cnt <= cnt + 1'b1;
    end

    assign last = (cnt == CW'(MAX_POLLS - 1));

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(MAX_POLLS)); // R4
endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
    import fbp_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter int BUF_WORDS = 32,
    parameter int MAX_POLLS = 8,
    localparam int OFF_W = $clog2(BUF_WORDS),
    localparam int LEN_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [15:0]       wr_data,
    output logic              fl_we,
    output logic              fl_re,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [15:0]       fl_wdata,
    input  logic [15:0]       fl_rdata,
    output logic              done,
    output logic              aborted,
    output logic [7:0]        status,
    output logic              req_err
);
    fbp_state_e        state, nxt;
    logic [ADDR_W-1:0] start_q;
    logic [LEN_W-1:0]  len_q, idx_q;
    logic [7:0]        status_q;
    logic              abort_q, err_q;
    logic              req_ok, tmr_clr, tmr_step, tmr_last;
    fbp_bus_t          bus;

    fbp_req_check #(.BUF_WORDS(BUF_WORDS)) u_check (
        .offset (req_addr[OFF_W-1:0]),
        .len    (req_len),
        .ok     (req_ok)
    );

    fbp_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .step (tmr_step),
        .last (tmr_last)
    );

    always_comb begin
        nxt       = state;
        bus       = '{we: 1'b0, re: 1'b0, data: 16'h0000};
        fl_addr   = start_q;
        req_ready = 1'b0;
        wr_ready  = 1'b0;
        tmr_clr   = 1'b0;
        tmr_step  = 1'b0;
        unique case (state)
            S_IDLE: begin
                req_ready = 1'b1;
                tmr_clr   = 1'b1;
                if (req_valid && req_ok) nxt = S_SETUP;
            end
            S_SETUP: begin
                bus = '{we: 1'b1, re: 1'b0, data: cmd_word(CMD_BUF_SETUP)};
                nxt = S_AV_RD;
            end
            S_AV_RD: begin
                bus.re = 1'b1;
                nxt    = S_AV_CHK;
            end
            S_AV_CHK: begin
                if (fl_rdata[STAT_READY_BIT]) nxt = S_COUNT;
                else if (tmr_last)            nxt = S_RDARR;
                else begin
                    tmr_step = 1'b1;
                    nxt      = S_SETUP;
                end
            end
            S_COUNT: begin
                bus = '{we: 1'b1, re: 1'b0, data: {8'h00, 8'(len_q - LEN_W'(1))}};
                nxt = S_DATA;
            end
            S_DATA: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    bus     = '{we: 1'b1, re: 1'b0, data: wr_data};
                    fl_addr = start_q + ADDR_W'(idx_q);
                    if (idx_q == len_q - LEN_W'(1)) nxt = S_CONF;
                end
            end
            S_CONF: begin
                bus = '{we: 1'b1, re: 1'b0, data: cmd_word(CMD_CONFIRM)};
                nxt = S_DN_RD;
            end
            S_DN_RD: begin
                bus.re = 1'b1;
                nxt    = S_DN_CHK;
            end
            S_DN_CHK: nxt = fl_rdata[STAT_READY_BIT] ? S_RDARR : S_DN_RD;
            S_RDARR: begin
                bus = '{we: 1'b1, re: 1'b0, data: cmd_word(CMD_READ_ARRAY)};
                nxt = S_FIN;
            end
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            start_q  <= '0;
            len_q    <= '0;
            idx_q    <= '0;
            status_q <= '0;
            abort_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state <= nxt;
            err_q <= (state == S_IDLE) && req_valid && !req_ok;
            if (state == S_IDLE && req_valid && req_ok) begin
                start_q <= req_addr;
                len_q   <= req_len;
                idx_q   <= '0;
                abort_q <= 1'b0;
            end
            if (state == S_AV_CHK || state == S_DN_CHK) status_q <= fl_rdata[7:0];
            if (state == S_AV_CHK && !fl_rdata[STAT_READY_BIT] && tmr_last) abort_q <= 1'b1;
            if (state == S_DATA && wr_valid) idx_q <= idx_q + LEN_W'(1);
        end
    end

    assign fl_we    = bus.we;
    assign fl_re    = bus.re;
    assign fl_wdata = bus.data;
    assign done     = (state == S_FIN);
    assign aborted  = done && abort_q;
    assign status   = status_q;
    assign req_err  = err_q;

    AST_BUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re)); // R10
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !fl_we && !fl_re); // R10
    AST_SETUP_THEN_READ: assert property (@(posedge clk) disable iff (rst)
        (state == S_SETUP) |=> fl_re && $stable(fl_addr)); // R3
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_err |-> !fl_we && !fl_re); // R1
    AST_COUNT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (state == S_COUNT) |-> (fl_wdata[7:0] < 8'(BUF_WORDS)) && (fl_wdata[15:8] == 8'h00)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_AFTER_RDARR: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(fl_we) && ($past(fl_wdata) == cmd_word(CMD_READ_ARRAY))); // R9
endmodule

// File: tb/test_flash_bufprog_seq.sv
module test_flash_bufprog_seq;
    localparam int ADDR_W = 23;
    localparam int BUFW   = 32;
    localparam int MAXP   = 8;
    localparam int LEN_W  = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0, req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              wr_valid = 1'b0, wr_ready;
    logic [15:0]       wr_data = '0;
    logic              fl_we, fl_re;
    logic [ADDR_W-1:0] fl_addr;
    logic [15:0]       fl_wdata;
    logic [15:0]       fl_rdata = '0;
    logic              done, aborted, req_err;
    logic [7:0]        status;

    int checks = 0, errors = 0;

    flash_bufprog_seq #(.ADDR_W(ADDR_W), .BUF_WORDS(BUFW), .MAX_POLLS(MAXP)) i_flash_bufprog_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .done(done), .aborted(aborted),
        .status(status), .req_err(req_err)
    );

    always #5 clk = ~clk;

    // flash status model
    int       av_left = 0, dn_left = 0;
    bit       ph_done = 0;
    bit       logging = 0;
    logic [7:0] busy_b = 8'h00, ready_b = 8'h80;
    always @(posedge clk) begin
        if (fl_re) begin
            if (!ph_done) begin
                if (av_left > 0) begin fl_rdata = {8'h00, busy_b}; av_left = av_left - 1; end
                else begin fl_rdata = {8'h00, ready_b}; ph_done = 1; end
            end else begin
                if (dn_left > 0) begin fl_rdata = {8'h00, busy_b}; dn_left = dn_left - 1; end
                else fl_rdata = {8'h00, ready_b};
            end
        end
    end

    // bus monitor
    logic [ADDR_W-1:0] wl_a [64];
    logic [15:0]       wl_d [64];
    int wcnt = 0, rcnt = 0, both_hi = 0;
    always @(negedge clk) begin
        if (!rst && logging) begin
            if (fl_we && wcnt < 64) begin wl_a[wcnt] = fl_addr; wl_d[wcnt] = fl_wdata; wcnt = wcnt + 1; end
            if (fl_re) rcnt = rcnt + 1;
            if (fl_we && fl_re) both_hi = both_hi + 1;
        end
    end

    logic [15:0] dat [32];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit req_legal(input logic [ADDR_W-1:0] a, input int n);
        return (n >= 1) && (n <= BUFW) && ((int'(a % BUFW) + n) <= BUFW);
    endfunction

    function automatic logic [ADDR_W+15:0] exp_write(input int k, input logic [ADDR_W-1:0] a,
                                                    input int n, input int nset, input bit ab);
        if (k < nset) return {a, 16'h00E8};
        if (ab) return {a, 16'h00FF};
        if (k == nset) return {a, 8'h00, 8'(n - 1)};
        if (k < nset + 1 + n) return {a + ADDR_W'(k - nset - 1), dat[k - nset - 1]};
        if (k == nset + 1 + n) return {a, 16'h00D0};
        return {a, 16'h00FF};
    endfunction

    task automatic send_req(input logic [ADDR_W-1:0] a, input int n);
        req_valid = 1'b1; req_addr = a; req_len = LEN_W'(n);
        forever begin
            #1;
            if (req_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] d);
        wr_valid = 1'b1; wr_data = d;
        forever begin
            #1;
            if (wr_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic run_txn(input logic [ADDR_W-1:0] a, input int n, input int ab, input int db);
        bit legal, abort_exp, rdy_bad;
        int nset, nwr, guard;
        legal     = req_legal(a, n);
        abort_exp = (ab >= MAXP);
        nset      = abort_exp ? MAXP : ab + 1;
        busy_b    = 8'($urandom) & 8'h7F;
        ready_b   = 8'h80 | (8'($urandom) & 8'h7F);
        av_left = ab; dn_left = db; ph_done = 0;
        wcnt = 0; rcnt = 0;
        logging = 1;
        for (int i = 0; i < 32; i++) dat[i] = 16'($urandom);
        send_req(a, n);
        if (!legal) begin
            chk(req_err === 1'b1, "R1/R2 refused request flags req_err", 32'(req_err), 1);
            @(negedge clk);
            chk(req_err === 1'b0, "R1/R2 req_err lasts one cycle", 32'(req_err), 0);
            repeat (3) @(negedge clk);
            chk(wcnt == 0 && rcnt == 0, "R1/R2 refused request makes no bus access", 32'(wcnt + rcnt), 0);
            chk(req_ready === 1'b1, "R1/R2 ready after refusal", 32'(req_ready), 1);
            logging = 0;
            return;
        end
        chk(req_err === 1'b0, "R2 legal request not flagged", 32'(req_err), 0);
        if (!abort_exp) begin
            for (int i = 0; i < n; i++) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                send_word(dat[i]);
            end
        end
        guard = 0; rdy_bad = 0;
        while (done !== 1'b1 && guard < 3000) begin
            if (req_ready !== 1'b0) rdy_bad = 1;
            @(negedge clk); guard++;
        end
        chk(done === 1'b1, "R9 done pulse reached", 32'(done), 1);
        chk(!rdy_bad, "R10 req_ready low while busy", 32'(rdy_bad), 0);
        chk(aborted === abort_exp, "R4 aborted flag at done", 32'(aborted), 32'(abort_exp));
        chk(status === (abort_exp ? busy_b : ready_b), "R9 final status byte", 32'(status),
            32'(abort_exp ? busy_b : ready_b));
        nwr = abort_exp ? nset + 1 : nset + n + 3;
        chk(wcnt == nwr, "R4/R6 number of bus writes", 32'(wcnt), 32'(nwr));
        for (int k = 0; k < wcnt && k < nwr; k++) begin
            logic [ADDR_W+15:0] e;
            e = exp_write(k, a, n, nset, abort_exp);
            chk({wl_a[k], wl_d[k]} === e,
                (k < nset) ? "R3 setup write" : (k == nwr - 1) ? "R9 read-array write" :
                (k == nset) ? "R5 count write" : (k == nwr - 2) ? "R7 confirm write" : "R6 data write",
                32'({wl_a[k], wl_d[k]}), 32'(e));
        end
        chk(rcnt == nset + (abort_exp ? 0 : db + 1), "R8 status read count", 32'(rcnt),
            32'(nset + (abort_exp ? 0 : db + 1)));
        chk(both_hi == 0, "R10 strobes exclusive", 32'(both_hi), 0);
        @(negedge clk);
        chk(done === 1'b0 && req_ready === 1'b1, "R9 done one cycle, idle again",
            32'({done, req_ready}), 32'b01);
        logging = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1 && done === 1'b0 && req_err === 1'b0 && fl_we === 1'b0 && fl_re === 1'b0,
            "R10 reset state", 32'({req_ready, done, req_err, fl_we, fl_re}), 32'b10000);
        // R1 illegal counts
        run_txn(23'h000100, 0, 0, 0);
        run_txn(23'h000100, 33, 0, 0);
        run_txn(23'h000100, 63, 0, 0);
        // R2 boundary crossing and exact fits
        run_txn(23'h00021E, 3, 0, 0);
        run_txn(23'h00041F, 1, 0, 0);
        run_txn(23'h000600, 32, 0, 2);
        // R4 ready on last permitted attempt, then true abort
        run_txn(23'h000820, 4, MAXP - 1, 1);
        run_txn(23'h000A40, 5, MAXP, 0);
        // R8 long completion poll
        run_txn(23'h7FFFE0, 8, 0, 12);
        // random mix
        for (int t = 0; t < 40; t++) begin
            int n, off;
            logic [ADDR_W-1:0] a;
            n   = $urandom_range(1, 32);
            off = $urandom_range(0, 32 - n);
            if ($urandom_range(0, 7) == 0) off = $urandom_range(33 - n > 31 ? 31 : 33 - n, 31);
            a   = {ADDR_W'($urandom) & ~ADDR_W'(31)} | ADDR_W'(off);
            run_txn(a, n, $urandom_range(0, MAXP + 1), $urandom_range(0, 5));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule